// File: doc/BRIEF.md
# Configurable Wake-up Input Monitor

This block watches four external wake inputs, grouped as two pairs (inputs 0/1 and inputs 2/3). Each pair has a two-bit sensitivity setting held in a small control register. While the system sits in a low-power mode (sleep or stop), any input whose synchronized level qualifies under its pair's setting sets a sticky wake-source flag, and the first such flag produces a one-cycle wake request for the power controller.

The four status bits carry two meanings. Until software performs its first status read after a wake, and always in a low-power mode, they show the latched wake-source flags. Once that read has happened, and the system is in an active mode (normal or standby), they show the live, synchronized input levels. A watchdog timeout that arrives before that first read discards the latched flags. The read strobe returns the flags on the same cycle and clears them at the end of it.

Top module: `wake_input_monitor`

## Requirements
- R1: After reset the control register is 0000, no wake flag is set, `wake_req_o` is low and, in an active mode, `stat_o` reads 0000 until the first status read.
- R2: Control bits [1:0] configure inputs 0 and 1; control bits [3:2] configure inputs 2 and 3; a write of one field has no effect on the other pair's behaviour.
- R3: Sensitivity codes per pair: 00 = inputs disabled (never latch), 01 = latch on high level, 10 = latch on low level, 11 = latch on either level.
- R4: With `pmode_i` = 10 (sleep) or 11 (stop), a qualifying input sets its flag bit in `stat_o` (bit i for input i); the flag stays set after the input returns to a non-qualifying level.
- R5: With `pmode_i` = 00 (normal) or 01 (standby), no flag is ever set and no wake request is raised, whatever the inputs and settings.
- R6: `wake_req_o` is high for exactly one cycle when the first flag is set while no flag was set; later flags in the same wake episode give no further pulse.
- R7: After a wake, `stat_o` keeps showing the flags in an active mode until a cycle with `stat_rd_i` high; that cycle still shows the flags, and from the next cycle on `stat_o` shows the live input levels (1 = high).
- R8: A `wdt_tmo_i` pulse before the first status read clears all flags; a pulse after that read leaves the live status unchanged.
- R9: Each input passes through two flip-flops: a level change applied before a clock edge is visible in the live status after the second edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pins_i | input | 4 | Raw wake inputs, bit i = input i |
| pmode_i | input | 2 | Power mode: 00 normal, 01 standby, 10 sleep, 11 stop |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data, [1:0] pair 0/1, [3:2] pair 2/3 |
| stat_rd_i | input | 1 | One-cycle status read strobe |
| wdt_tmo_i | input | 1 | Watchdog timeout pulse |
| stat_o | output | 4 | Status: wake flags or live levels |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
On every cycle the assertions check that the wake request never lasts two cycles, that flags hold still in active modes absent a read or timeout, that a timeout before the first read empties the flags, that a read in an active mode marks the read as done, and that a pair set to disabled never gains a flag. Only the directed scenarios can show the full sensitivity table across both pairs, the two-edge synchronizer latency, and the switch of the status meaning from flags to live levels around the read strobe.

// File: rtl/wkm_pkg.sv
package wkm_pkg;

  typedef enum logic [1:0] {
    SENS_OFF  = 2'b00,
    SENS_HIGH = 2'b01,
    SENS_LOW  = 2'b10,
    SENS_ANY  = 2'b11
  } sens_e;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_STANDBY = 2'b01,
    PM_SLEEP   = 2'b10,
    PM_STOP    = 2'b11
  } pmode_e;

  function automatic logic is_low_power(input pmode_e m);
    return (m == PM_SLEEP) || (m == PM_STOP);
  endfunction

endpackage

// File: rtl/wkm_sync.sv
module wkm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/wkm_qualify.sv
module wkm_qualify
  import wkm_pkg::*;
#(
  parameter int N_PAIRS = 2,
  localparam int W      = 2 * N_PAIRS
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] cfg_i,
  output logic [W-1:0] hit_o
);

  for (genvar i = 0; i < W; i++) begin : g_in
    localparam int P = i / 2;
    sens_e sens;
    assign sens = sens_e'(cfg_i[2*P +: 2]);

    always_comb begin
      case (sens)
        SENS_HIGH: hit_o[i] = lvl_i[i];
        SENS_LOW:  hit_o[i] = ~lvl_i[i];
        SENS_ANY:  hit_o[i] = 1'b1;
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/wkm_flags.sv
module wkm_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lp_i,
  input  logic [W-1:0] hit_i,
  input  logic         rd_i,
  input  logic         wdt_i,
  output logic [W-1:0] flags_o,
  output logic         rd_done_o,
  output logic         wake_o
);

  logic [W-1:0] flags_q, flags_d, set_bits, kept;
  logic         rd_done_q, rd_done_d;
  logic         wake_q, wake_d;
  logic         wdt_clr, fresh;

  always_comb begin
    set_bits  = hit_i & {W{lp_i}};
    wdt_clr   = wdt_i && !rd_done_q;
    kept      = rd_i ? '0 : flags_q;
    fresh     = |(set_bits & ~flags_q);
    flags_d   = wdt_clr ? '0 : (kept | set_bits);
    rd_done_d = rd_done_q;
    if (fresh && !wdt_clr) rd_done_d = 1'b0;
    else if (rd_i)         rd_done_d = 1'b1;
    wake_d    = ~|flags_q && |flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      rd_done_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      rd_done_q <= rd_done_d;
      wake_q    <= wake_d;
    end
  end

  assign flags_o   = flags_q;
  assign rd_done_o = rd_done_q;
  assign wake_o    = wake_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  a_r5_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_i && !rd_i && !wdt_i) |=> $stable(flags_q));

  a_r8_wdt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_i && !rd_done_q) |=> (flags_q == '0));

  a_r7_read_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !lp_i) |=> rd_done_q);

endmodule

// File: rtl/wake_input_monitor.sv
module wake_input_monitor
  import wkm_pkg::*;
#(
  parameter int N_PAIRS   = 2,
  parameter int SYNC_STGS = 2,
  localparam int W        = 2 * N_PAIRS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   pins_i,
  input  logic [1:0]   pmode_i,
  input  logic         ctrl_we_i,
  input  logic [3:0]   ctrl_wdata_i,
  input  logic         stat_rd_i,
  input  logic         wdt_tmo_i,
  output logic [3:0]   stat_o,
  output logic         wake_req_o
);

  logic [W-1:0] ctrl_q, ctrl_d;
  logic [W-1:0] live, hit, flags;
  logic         lp, rd_done;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we_i) ctrl_d = ctrl_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign lp = is_low_power(pmode_e'(pmode_i));

  wkm_sync #(.W(W), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (live)
  );

  wkm_qualify #(.N_PAIRS(N_PAIRS)) u_qual (
    .lvl_i (live),
    .cfg_i (ctrl_q),
    .hit_o (hit)
  );

  wkm_flags #(.W(W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_i      (lp),
    .hit_i     (hit),
    .rd_i      (stat_rd_i),
    .wdt_i     (wdt_tmo_i),
    .flags_o   (flags),
    .rd_done_o (rd_done),
    .wake_o    (wake_req_o)
  );

  assign stat_o = (lp || !rd_done) ? flags : live;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair_chk
    a_r3_off_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2*p +: 2] == SENS_OFF && flags[2*p +: 2] == 2'b00)
        |=> (flags[2*p +: 2] == 2'b00));
  end

endmodule

// File: tb/tb_wake_input_monitor.sv
module tb_wake_input_monitor;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pins_i;
  logic [1:0] pmode_i;
  logic       ctrl_we_i;
  logic [3:0] ctrl_wdata_i;
  logic       stat_rd_i;
  logic       wdt_tmo_i;
  logic [3:0] stat_o;
  logic       wake_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  int wake_cnt = 0;

  always #5 clk = ~clk;

  wake_input_monitor dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pins_i       (pins_i),
    .pmode_i      (pmode_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .stat_rd_i    (stat_rd_i),
    .wdt_tmo_i    (wdt_tmo_i),
    .stat_o       (stat_o),
    .wake_req_o   (wake_req_o)
  );

  always @(negedge clk) if (rst_n === 1'b1 && wake_req_o === 1'b1) wake_cnt++;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pins_i = '0; pmode_i = 2'b00; ctrl_we_i = 1'b0;
    ctrl_wdata_i = '0; stat_rd_i = 1'b0; wdt_tmo_i = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    wake_cnt = 0;
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    step(1);
    ctrl_we_i = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd_i = 1'b1;
    step(1);
    stat_rd_i = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_tmo_i = 1'b1;
    step(1);
    wdt_tmo_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    pins_i = 4'b1111;
    step(4);
    chk("R1 status after reset", stat_o, 4'b0000);
    chk("R1 wake request after reset", {3'b0, wake_req_o}, 4'b0000);
    pmode_i = 2'b10;
    step(3);
    chk("R1 control cleared, no latch", stat_o, 4'b0000);
  endtask

  task automatic t_sensitivity();
    for (int ch = 0; ch < 4; ch++) begin
      for (int cl = 0; cl < 4; cl++) begin
        logic [3:0] exp;
        do_reset();
        pins_i = 4'b0101;
        wr_ctrl({ch[1:0], cl[1:0]});
        step(3);
        wake_cnt = 0;
        pmode_i = 2'b10;
        step(3);
        exp = {ch[1:0], cl[1:0]};
        chk("R2/R3 flags per pair code", stat_o, exp);
        chk("R6 wake pulse count", wake_cnt[3:0], (exp != 0) ? 4'd1 : 4'd0);
      end
    end
  endtask

  task automatic t_persist();
    do_reset();
    wr_ctrl(4'b0101);
    step(3);
    pmode_i = 2'b11;
    step(2);
    pins_i = 4'b0001;
    step(4);
    chk("R4 flag latched in stop", stat_o, 4'b0001);
    pins_i = 4'b0000;
    step(4);
    chk("R4 flag held after input drops", stat_o, 4'b0001);
    pins_i = 4'b0100;
    step(4);
    chk("R4 second flag added", stat_o, 4'b0101);
    chk("R6 only one pulse per episode", wake_cnt[3:0], 4'd1);
  endtask

  task automatic t_active_modes();
    do_reset();
    wr_ctrl(4'b1111);
    pins_i = 4'b1010; step(5);
    pins_i = 4'b0101; step(5);
    chk("R5 no latch in normal", stat_o, 4'b0000);
    pmode_i = 2'b01;
    pins_i = 4'b1100; step(5);
    chk("R5 no latch in standby", stat_o, 4'b0000);
    chk("R5 no wake request in active modes", wake_cnt[3:0], 4'd0);
    pmode_i = 2'b10;
    step(3);
    chk("R5 same setup latches in sleep", stat_o, 4'b1111);
  endtask

  task automatic t_read_switch();
    do_reset();
    wr_ctrl(4'b0100);
    step(3);
    pmode_i = 2'b10;
    pins_i = 4'b0100;
    step(5);
    pmode_i = 2'b00;
    pins_i = 4'b1011;
    step(4);
    chk("R7 flags shown before read", stat_o, 4'b0100);
    stat_rd_i = 1'b1;
    #1;
    chk("R7 read cycle returns flags", stat_o, 4'b0100);
    step(1);
    stat_rd_i = 1'b0;
    #1;
    chk("R7 live levels after read", stat_o, 4'b1011);
    pins_i = 4'b0001;
    step(3);
    chk("R7 live levels follow inputs", stat_o, 4'b0001);
  endtask

  task automatic t_wdt();
    do_reset();
    wr_ctrl(4'b0011);
    step(3);
    pmode_i = 2'b11;
    step(4);
    chk("R8 flags latched before timeout", stat_o, 4'b0011);
    pmode_i = 2'b00;
    step(1);
    pulse_wdt();
    chk("R8 timeout before read clears flags", stat_o, 4'b0000);
    pins_i = 4'b0110;
    step(3);
    pulse_rd();
    chk("R8 live after read", stat_o, 4'b0110);
    pins_i = 4'b1000;
    step(3);
    pulse_wdt();
    chk("R8 timeout after read keeps live status", stat_o, 4'b1000);
  endtask

  task automatic t_sync();
    do_reset();
    pulse_rd();
    chk("R9 live zero before change", stat_o, 4'b0000);
    pins_i = 4'b1111;
    step(1);
    chk("R9 not visible after one edge", stat_o, 4'b0000);
    step(1);
    chk("R9 visible after two edges", stat_o, 4'b1111);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_sensitivity();
    t_persist();
    t_active_modes();
    t_read_switch();
    t_wdt();
    t_sync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule